// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block is the write-only serial front end of a display controller. A host shifts bytes in, most significant bit first, on a serial clock while the part is selected. Every group of eight rising serial-clock edges becomes one parallel byte. A side-band tag line tells whether that byte is display data or a command. The tag is sampled on the edge that completes the byte. There is no read path: the interface only accepts writes.

The part is selected when three inputs agree: a serial-mode strap held low, an active-low select held low and an active-high select held high. While it is not selected, the bit counter and the shift register are held cleared. A byte that is cut short by a deselect is therefore lost, and the next byte starts again at bit 7. All serial inputs are brought into the system clock domain through two-flop synchronisers. A serial clock edge is recognised as a rising transition of the synchronised copy, so the system clock must run several times faster than the serial clock.

A small state machine controls the byte flow. Its states are:
- `ST_OFF`: deselected, with the counter and shifter held clear.
- `ST_SHIFT`: collecting bits.
- `ST_LOAD`: a one-cycle state that presents a completed byte.

Its transitions are:
- `T_WAKE`: OFF to SHIFT, when selected.
- `T_DROP`: SHIFT to OFF, when deselected.
- `T_FULL`: SHIFT to LOAD, on the eighth edge.
- `T_NEXT`: LOAD to SHIFT, while still selected.
- `T_LOAD_OFF`: LOAD to OFF, when deselected.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `byte_valid` is 0, `rx_byte` is 0x00 and `rx_is_data` is 0.
- R2: The receiver is selected only when `ser_mode_n`=0, `sel_n`=0 and `sel`=1. If any of the three differs, serial clock edges produce no byte and leave `rx_byte` and `rx_is_data` unchanged.
- R3: Bits are sampled from `sdin` on rising `sclk` edges. The first bit becomes `rx_byte[7]` and the eighth becomes `rx_byte[0]`.
- R4: The eighth rising edge of a byte produces exactly one `byte_valid` pulse, and that pulse lasts a single system clock cycle.
- R5: `dc_tag` is sampled on the eighth edge of each byte and appears on `rx_is_data`: 1 means display data, 0 means a command. Its value on the first seven edges has no effect.
- R6: Deselecting the part clears the bit counter and the shift register. A partial byte is dropped without a pulse, and after reselection the next edge is taken as bit 7.
- R7: Bytes may follow back to back with no gap. The ninth edge after the start of a byte is bit 7 of the next byte.
- R8: `rx_byte` and `rx_is_data` change only when `byte_valid` rises, and they hold their values until the next byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_mode_n | input | 1 | Serial-mode strap, low selects serial operation |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| sclk | input | 1 | Serial clock, bits taken on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| dc_tag | input | 1 | Data/command tag, high = display data |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_byte | output | 8 | Last completed byte |
| rx_is_data | output | 1 | Tag of the last completed byte |

## Verification
Bytes with asymmetric bit patterns (0xA5, 0x3C, 0x01, 0x80, 0x12) are sent so that a reversed bit order or an off-by-one count gives a different value. The tag is toggled on the first seven edges and set differently on the eighth, which separates sampling at the completing edge from sampling at any other edge. Each of the three select inputs is taken out of its active state in turn, to show that each one gates the receiver on its own. A deselect in the middle of a byte followed by a fresh byte shows whether stale bits or a stale count survive the deselect, and a back-to-back pair shows that the count wraps cleanly from one byte to the next.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbr_edge.sv
module sbr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;

    // R7: a rise needs a low sample first, so two rises are never adjacent
    a_r7_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sbr_shifter.sv
module sbr_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] word_next,
    output logic              last
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            count <= '0;
        end else if (clear) begin
            shreg <= '0;
            count <= '0;
        end else if (step) begin
            shreg <= word_next;
            count <= last ? '0 : count + 1'b1;
        end
    end

    assign last      = (count == LAST_IDX);
    assign word_next = {shreg[BYTE_W-2:0], bit_in};

    // R6: a clear leaves the counter and shifter empty
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && shreg == '0));

    // R3: each step below the last advances the bit index by one
    a_r3_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !last) |=> (count == $past(count) + 1'b1));

    // R7: the completing step wraps the index to bit 7 of the next byte
    a_r7_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && last) |=> (count == '0));
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              dc_tag,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data
);
    import sbr_pkg::*;

    localparam int N_IN = 6;

    logic [N_IN-1:0]   raw_in, syn_in;
    logic              s_mode_n, s_sel_n, s_sel, s_sclk, s_sdin, s_tag;
    logic              active, sclk_rise;
    logic              sh_clear, sh_step, sh_last;
    logic [BYTE_W-1:0] word_next;
    rx_state_t         state, state_nx;

    assign raw_in = {ser_mode_n, sel_n, sel, sclk, sdin, dc_tag};

    sbr_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {s_mode_n, s_sel_n, s_sel, s_sclk, s_sdin, s_tag} = syn_in;
    assign active = ~s_mode_n & ~s_sel_n & s_sel;

    sbr_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (s_sclk),
        .rise  (sclk_rise)
    );

    assign sh_clear = ~active | (state == ST_OFF);
    assign sh_step  = active & sclk_rise & (state == ST_SHIFT);

    sbr_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .step      (sh_step),
        .bit_in    (s_sdin),
        .word_next (word_next),
        .last      (sh_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (active) state_nx = ST_SHIFT;                 // T_WAKE
            ST_SHIFT: if (!active) state_nx = ST_OFF;                  // T_DROP
                      else if (sh_step && sh_last) state_nx = ST_LOAD; // T_FULL
            ST_LOAD:  state_nx = active ? ST_SHIFT : ST_OFF;           // T_NEXT / T_LOAD_OFF
            default:  state_nx = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // byte and tag capture on the completing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte    <= '0;
            rx_is_data <= 1'b0;
        end else if (state == ST_SHIFT && active && sh_step && sh_last) begin
            rx_byte    <= word_next;
            rx_is_data <= s_tag;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_LOAD: byte_valid = 1'b1;
            default: byte_valid = 1'b0;
        endcase
    end

    // R4: the strobe never lasts more than one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R8: byte and tag hold unless a new byte is being presented
    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> ($stable(rx_byte) && $stable(rx_is_data)));

    // R2: while deselected, no byte can be presented in the next cycle
    a_r2_idle_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !byte_valid || $past(state == ST_SHIFT));

    // R7: no serial edge can arrive during the one-cycle load state
    a_r7_no_edge_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> !sclk_rise);

    // R6: a deselected shifting state always falls back to idle
    a_r6_drop_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !active) |=> (state == ST_OFF));
endmodule

// File: tb/serial_byte_rx_bench.sv
module serial_byte_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH_CYC     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sel = 1'b0;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       dc_tag = 1'b0;
    logic       byte_valid;
    logic [7:0] rx_byte;
    logic       rx_is_data;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int run = 0;
    int max_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_byte_rx u_serial_byte_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_mode_n (ser_mode_n),
        .sel_n      (sel_n),
        .sel        (sel),
        .sclk       (sclk),
        .sdin       (sdin),
        .dc_tag     (dc_tag),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .rx_is_data (rx_is_data)
    );

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (run == 0) pulses++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select_on();
        ser_mode_n = 1'b0; sel_n = 1'b0; sel = 1'b1;
        idle(6);
    endtask

    task automatic select_off();
        sel_n = 1'b1; sel = 1'b0;
        idle(6);
    endtask

    // one serial bit: low phase with data set up, then high phase
    task automatic send_bit(input logic b, input logic tag);
        @(negedge clk);
        sdin = b; dc_tag = tag; sclk = 1'b0;
        idle(PH_CYC);
        sclk = 1'b1;
        idle(PH_CYC);
        sclk = 1'b0;
    endtask

    // eight bits MSB first; tag is inverted on edges 1-7, tag_last on edge 8
    task automatic send_byte(input logic [7:0] v, input logic tag_last);
        for (int i = 7; i >= 0; i--)
            send_bit(v[i], (i == 0) ? tag_last : ~tag_last);
    endtask

    task automatic t_reset();
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 rx_byte", int'(rx_byte), 0);
        chk("R1 rx_is_data", int'(rx_is_data), 0);
    endtask

    task automatic t_data_byte();
        int p0 = pulses;
        select_on();
        send_byte(8'hA5, 1'b1);
        idle(8);
        chk("R4 one pulse for data byte", pulses - p0, 1);
        chk("R3 MSB-first byte 0xA5", int'(rx_byte), 8'hA5);
        chk("R5 tag high gives data", int'(rx_is_data), 1);
    endtask

    task automatic t_cmd_byte();
        int p0 = pulses;
        send_byte(8'h3C, 1'b0);
        idle(8);
        chk("R4 one pulse for command byte", pulses - p0, 1);
        chk("R3 byte 0x3C", int'(rx_byte), 8'h3C);
        chk("R5 tag low on eighth edge gives command", int'(rx_is_data), 0);
    endtask

    task automatic t_back_to_back();
        int p0 = pulses;
        send_byte(8'h01, 1'b1);
        send_bit(1'b1, 1'b1);   // first bit of the next byte, no gap
        idle(2);
        chk("R7 first byte 0x01", int'(rx_byte), 8'h01);
        chk("R7 first byte tag", int'(rx_is_data), 1);
        for (int i = 6; i >= 0; i--) send_bit(1'b0, (i == 0) ? 1'b0 : 1'b1);
        idle(8);
        chk("R7 second byte 0x80", int'(rx_byte), 8'h80);
        chk("R7 second byte tag", int'(rx_is_data), 0);
        chk("R7 two pulses", pulses - p0, 2);
    endtask

    task automatic t_partial_drop();
        int p0 = pulses;
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        select_off();
        chk("R6 no pulse for partial byte", pulses - p0, 0);
        chk("R6 byte unchanged after drop", int'(rx_byte), 8'h80);
        select_on();
        send_byte(8'h12, 1'b1);
        idle(8);
        chk("R6 fresh byte after reselect", int'(rx_byte), 8'h12);
        chk("R6 exactly one pulse after reselect", pulses - p0, 1);
    endtask

    task automatic t_gating();
        int p0 = pulses;
        ser_mode_n = 1'b1;
        idle(6);
        send_byte(8'hFF, 1'b0);
        idle(8);
        chk("R2 mode strap high blocks bytes", pulses - p0, 0);
        ser_mode_n = 1'b0; sel = 1'b0;
        idle(6);
        send_byte(8'hFF, 1'b0);
        idle(8);
        chk("R2 active-high select low blocks bytes", pulses - p0, 0);
        sel = 1'b1; sel_n = 1'b1;
        idle(6);
        send_byte(8'hFF, 1'b0);
        idle(8);
        chk("R2 active-low select high blocks bytes", pulses - p0, 0);
        chk("R2 byte unchanged while gated", int'(rx_byte), 8'h12);
        chk("R2 tag unchanged while gated", int'(rx_is_data), 1);
    endtask

    task automatic t_hold();
        idle(50);
        chk("R8 byte held", int'(rx_byte), 8'h12);
        chk("R8 tag held", int'(rx_is_data), 1);
        chk("R4 pulse width one cycle", max_run, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        idle(4);
        t_reset();
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_data_byte();
        t_cmd_byte();
        t_back_to_back();
        t_partial_drop();
        t_gating();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule